// File: doc/BRIEF.md
# NAND Command Front End

This block is the device side of a small-page NAND memory's command interface. Every transfer shares one 8-bit bus. A host write carries two qualifiers. With the command qualifier high, the byte is a command. With the address qualifier high, it is an address byte. The block decodes these strobes into operations: reset, identifier read, status read, and page read. It splits the page-read address into a column, a page region and a row. It also drives a ready/busy output, and every busy interval is counted in clock cycles.

Reads leave the block on a valid/ready stream. Each accepted transfer stands for one read-enable pulse. The block holds `rd_data` steady while `rd_valid` is high and `rd_ready` is low, and it advances only when both are high. Page data comes from a behavioural stand-in for the array, which computes each byte from the row and the column. The write side has no back-pressure: the block samples every byte presented with `wr_valid` in that same cycle.

After reset, a power-up recovery window holds the block busy and makes it deaf to writes. A reset command always forces a busy interval, even when the block was already ready.

Top module: `nand_cmd_front`

## Requirements
- R1: After `rst_n` rises, `rb_n` stays low for exactly PWR_CYC clock cycles. Every write accepted during that window is ignored.
- R2: A write with `wr_cle`=1 and `wr_ale`=0 is a command. A write with `wr_ale`=1 and `wr_cle`=0 is an address byte. A write with both qualifiers high, or with neither, changes nothing.
- R3: Command FFh drives `rb_n` low for exactly RST_CYC cycles, counted from the cycle after the command, whether the block was ready or busy. Afterwards no read data is offered.
- R4: Command 90h followed by address byte 00h offers identifier bytes that alternate between ECh and DEV_CODE, starting with ECh. Any other address byte offers no data.
- R5: Command 70h is accepted even while busy. Every byte it offers has bit 7 equal to `wp_n`, bit 6 equal to 1 when ready, and all other bits 0.
- R6: A read command takes 1+ROW_CYCLES address bytes. The first is the column byte, and the row bytes follow least significant first. After the last address byte, `rb_n` is low for exactly RD_CYC cycles, and only then does `rd_valid` rise.
- R7: A page byte equals row[7:0] XOR col[7:0] XOR col[9:8], with col[9:8] zero-extended to 8 bits. Command 50h selects the spare area, col = 512 + (column byte mod 16).
- R8: Command 00h selects col = column byte. Command 01h selects the second half, col = 256 + column byte.
- R9: Each page handshake advances col by one. After col 527, col returns to 0 and the row increments.
- R10: While busy, every command except FFh and 70h is ignored, and so is every address byte.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds and no state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (models power-on) |
| wr_valid | input | 1 | One host write strobe this cycle |
| wr_cle | input | 1 | Command qualifier for the write |
| wr_ale | input | 1 | Address qualifier for the write |
| wr_data | input | 8 | Shared bus byte written by the host |
| wp_n | input | 1 | Write-protect level, 1 = not protected |
| rd_valid | output | 1 | A read byte is offered |
| rd_ready | input | 1 | Host takes the offered byte (one read-enable pulse) |
| rd_data | output | 8 | Offered read byte |
| rb_n | output | 1 | Ready/busy, 0 = busy |

## Verification
A mode register in the wrong state shows up at once as the wrong `rd_valid` or the wrong first byte, in the first cycle after the command or address write. A busy counter loaded with the wrong length, or started on the wrong event, moves the rising edge of `rb_n`, and that edge is checked on both neighbouring cycles. A wrong column or row register, or a wrong region, gives a wrong page byte on the first transfer after ready, and a broken wrap shows two transfers after column 527 is reached.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_RDADDR = 3'd1,
    M_IDADDR = 3'd2,
    M_PAGE   = 3'd3,
    M_ID     = 3'd4,
    M_STAT   = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    AREA_LO    = 2'd0,
    AREA_HI    = 2'd1,
    AREA_SPARE = 2'd2
  } area_e;

  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_RD_LO  = 8'h00;
  localparam logic [7:0] OP_RD_HI  = 8'h01;
  localparam logic [7:0] OP_RD_SP  = 8'h50;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] MAKER_ID  = 8'hEC;

endpackage

// File: rtl/nfc_strobe_decode.sv
module nfc_strobe_decode (
  input  logic wr_valid,
  input  logic wr_cle,
  input  logic wr_ale,
  input  logic lock,
  output logic cmd_stb,
  output logic addr_stb
);
  // A write with exactly one qualifier high counts; nothing counts during power-up lockout.
  always_comb begin
    cmd_stb  = wr_valid && wr_cle && !wr_ale && !lock;
    addr_stb = wr_valid && wr_ale && !wr_cle && !lock;
  end
endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
  parameter int PWR_CYC = 125,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             lock,
  output logic             busy
);
  localparam int PWR_W = $clog2(PWR_CYC + 1);
  localparam logic [PWR_W-1:0] PWR_END = PWR_W'(PWR_CYC);

  logic [PWR_W-1:0] pwr_cnt;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pwr_cnt <= '0;
    else if (pwr_cnt != PWR_END) pwr_cnt <= pwr_cnt + PWR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (start)          busy_cnt <= len;
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - CNT_W'(1);
  end

  always_comb begin
    lock = (pwr_cnt != PWR_END);
    busy = (busy_cnt != '0);
  end

  // R1: once the recovery window has ended it never reopens
  a_r1_lock_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !lock);

  // R3: a busy interval shrinks every cycle unless restarted
  a_r3_busy_drains: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> busy_cnt < $past(busy_cnt));
endmodule

// File: rtl/nfc_addr_ctrl.sv
module nfc_addr_ctrl
  import nfc_pkg::*;
#(
  parameter int ROW_CYCLES = 2,
  parameter int PAGE_BYTES = 528,
  parameter int DATA_BYTES = 512,
  parameter int COL_W      = $clog2(PAGE_BYTES),
  parameter int ROW_W      = 8 * ROW_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_area,
  input  area_e            area_in,
  input  logic             addr_in,
  input  logic [7:0]       din,
  input  logic             adv,
  output logic             addr_done,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  localparam int HALF_BYTES  = DATA_BYTES / 2;
  localparam int SPARE_BYTES = PAGE_BYTES - DATA_BYTES;
  localparam int SPARE_W     = $clog2(SPARE_BYTES);
  localparam int IDX_W       = $clog2(ROW_CYCLES + 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROW_CYCLES);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

  area_e            area;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] col_first;

  always_comb begin
    unique case (area)
      AREA_HI:    col_first = COL_W'(HALF_BYTES) + COL_W'(din);
      AREA_SPARE: col_first = COL_W'(DATA_BYTES) + COL_W'(din[SPARE_W-1:0]);
      default:    col_first = COL_W'(din);
    endcase
    addr_done = addr_in && (idx == IDX_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area <= AREA_LO;
      idx  <= '0;
      col  <= '0;
      row  <= '0;
    end else if (set_area) begin
      area <= area_in;
      idx  <= '0;
    end else if (addr_in) begin
      if (idx == '0) col <= col_first;
      for (int i = 0; i < ROW_CYCLES; i++) begin
        if (idx == IDX_W'(i + 1)) row[8*i +: 8] <= din;
      end
      if (idx != IDX_LAST) idx <= idx + IDX_W'(1);
    end else if (adv) begin
      if (col == COL_LAST) begin
        col <= '0;
        row <= row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  // R9: the column never leaves the page
  a_r9_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_LAST);

  // R9: stepping off the last column lands on column 0 of the next row
  a_r9_wrap_next_row: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !set_area && !addr_in && col == COL_LAST |=> col == '0 && row == $past(row) + ROW_W'(1));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nfc_pkg::*;
#(
  parameter int         ROW_CYCLES = 2,
  parameter int         PAGE_BYTES = 528,
  parameter int         DATA_BYTES = 512,
  parameter int         PWR_CYC    = 125,
  parameter int         RST_CYC    = 40,
  parameter int         RD_CYC     = 30,
  parameter logic [7:0] DEV_CODE   = 8'h75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_cle,
  input  logic       wr_ale,
  input  logic [7:0] wr_data,
  input  logic       wp_n,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rb_n
);
  localparam int COL_W   = $clog2(PAGE_BYTES);
  localparam int ROW_W   = 8 * ROW_CYCLES;
  localparam int MAX_CYC = (RST_CYC > RD_CYC) ? RST_CYC : RD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  mode_e            mode;
  logic             id_sel;
  logic             lock, busy;
  logic             cmd_stb, addr_stb, addr_ok;
  logic             is_rd_cmd, set_area, reset_cmd, addr_done;
  logic             rd_hs, adv;
  area_e            area_sel;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             busy_start;
  logic [CNT_W-1:0] busy_len;
  logic [7:0]       page_byte, status_byte;

  nfc_strobe_decode u_dec (
    .wr_valid (wr_valid),
    .wr_cle   (wr_cle),
    .wr_ale   (wr_ale),
    .lock     (lock),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb)
  );

  always_comb begin
    is_rd_cmd = (wr_data == OP_RD_LO) || (wr_data == OP_RD_HI) || (wr_data == OP_RD_SP);
    reset_cmd = cmd_stb && (wr_data == OP_RESET);
    set_area  = cmd_stb && !busy && is_rd_cmd;
    addr_ok   = addr_stb && !busy;
    unique case (wr_data)
      OP_RD_HI: area_sel = AREA_HI;
      OP_RD_SP: area_sel = AREA_SPARE;
      default:  area_sel = AREA_LO;
    endcase
    busy_start = reset_cmd || addr_done;
    busy_len   = reset_cmd ? CNT_W'(RST_CYC) : CNT_W'(RD_CYC);
  end

  nfc_busy_timer #(
    .PWR_CYC (PWR_CYC),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (busy_start),
    .len   (busy_len),
    .lock  (lock),
    .busy  (busy)
  );

  nfc_addr_ctrl #(
    .ROW_CYCLES (ROW_CYCLES),
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .COL_W      (COL_W),
    .ROW_W      (ROW_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_area  (set_area),
    .area_in   (area_sel),
    .addr_in   (addr_ok && mode == M_RDADDR),
    .din       (wr_data),
    .adv       (adv),
    .addr_done (addr_done),
    .col       (col),
    .row       (row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_IDLE;
      id_sel <= 1'b0;
    end else if (cmd_stb) begin
      if (wr_data == OP_RESET)       mode <= M_IDLE;
      else if (wr_data == OP_STATUS) mode <= M_STAT;
      else if (!busy) begin
        if (is_rd_cmd)                 mode <= M_RDADDR;
        else if (wr_data == OP_IDENT)  mode <= M_IDADDR;
        else                           mode <= M_IDLE;
      end
    end else if (addr_ok) begin
      if (mode == M_IDADDR) begin
        mode   <= (wr_data == 8'h00) ? M_ID : M_IDLE;
        id_sel <= 1'b0;
      end else if (mode == M_RDADDR && addr_done) begin
        mode <= M_PAGE;
      end
    end else if (rd_hs && mode == M_ID) begin
      id_sel <= ~id_sel;
    end
  end

  always_comb begin
    page_byte   = row[7:0] ^ col[7:0] ^ 8'(col[COL_W-1:8]);
    status_byte = {wp_n, !busy, 6'b000000};
    rd_valid    = (mode == M_ID) || (mode == M_STAT) || (mode == M_PAGE && !busy);
    unique case (mode)
      M_ID:    rd_data = id_sel ? DEV_CODE : MAKER_ID;
      M_STAT:  rd_data = status_byte;
      M_PAGE:  rd_data = page_byte;
      default: rd_data = 8'h00;
    endcase
    rd_hs = rd_valid && rd_ready;
    adv   = rd_hs && (mode == M_PAGE);
    rb_n  = !(busy || lock);
  end

  // R1: writes during the recovery window leave the mode alone
  a_r1_lockout_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    lock && wr_valid |=> $stable(mode));

  // R3: an accepted reset command makes the part busy in the next cycle
  a_r3_reset_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> !rb_n);

  // R4: identifier output opens with the maker byte
  a_r4_id_opens_with_maker: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_ID && $past(mode) != M_ID |-> rd_data == MAKER_ID);

  // R5: status bit 6 tracks the ready/busy pin
  a_r5_status_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_STAT |-> rd_data[6] == rb_n);

  // R6: no page data while a page load is in progress
  a_r6_no_data_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_PAGE && !rb_n |-> !rd_valid);

  // R10: busy blocks every command other than reset and status
  a_r10_busy_blocks_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_stb && wr_data != OP_RESET && wr_data != OP_STATUS |=> mode == $past(mode));

  // R11: an offered byte holds until taken
  a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ID || mode == M_PAGE) && rd_valid && !rd_ready && !wr_valid |=> $stable(rd_data));
endmodule

// File: tb/nand_cmd_front_bench.sv
`timescale 1ns/1ps
module nand_cmd_front_bench;
  localparam int         PWR = 125;
  localparam int         RST = 40;
  localparam int         RDC = 30;
  localparam logic [7:0] DEV = 8'h75;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_cle = 1'b0, wr_ale = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wp_n = 1'b1;
  logic       rd_ready = 1'b0;
  logic       rd_valid, rb_n;
  logic [7:0] rd_data;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  nand_cmd_front u_nand_cmd_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_cle   (wr_cle),
    .wr_ale   (wr_ale),
    .wr_data  (wr_data),
    .wp_n     (wp_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rb_n     (rb_n)
  );

  function automatic logic [7:0] pat(input logic [7:0] r, input int c);
    logic [9:0] cc;
    cc = 10'(c);
    return r ^ cc[7:0] ^ {6'b0, cc[9:8]};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    wr_valid = 1'b1; wr_cle = c; wr_ale = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_cle = 1'b0; wr_ale = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    chk(req, "rd_valid", {7'b0, rd_valid}, 8'h01);
    chk(req, "rd_data", rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !rb_n; i++) @(negedge clk);
  endtask

  task automatic page_addr(input logic [7:0] op, input logic [7:0] c, input logic [7:0] r0, input logic [7:0] r1);
    wr(1'b1, 1'b0, op);
    wr(1'b0, 1'b1, c);
    wr(1'b0, 1'b1, r0);
    wr(1'b0, 1'b1, r1);
  endtask

  // R1: reset state and power-up lockout
  task automatic t_powerup();
    int cnt;
    chk("R1", "rb_n at reset", {7'b0, rb_n}, 8'h00);
    chk("R1", "rd_valid at reset", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    wr(1'b1, 1'b0, 8'h70);
    cnt = 1;
    while (!rb_n && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R1", "lockout length", 8'(cnt), 8'(PWR));
    chk("R1", "status cmd in lockout ignored", {7'b0, rd_valid}, 8'h00);
  endtask

  // R3: reset from ready, exact busy length
  task automatic t_reset_ready();
    wr(1'b1, 1'b0, 8'hFF);
    chk("R3", "busy right after reset cmd", {7'b0, rb_n}, 8'h00);
    repeat (RST - 1) @(negedge clk);
    chk("R3", "busy on last cycle", {7'b0, rb_n}, 8'h00);
    @(negedge clk);
    chk("R3", "ready after interval", {7'b0, rb_n}, 8'h01);
    chk("R3", "no data after reset", {7'b0, rd_valid}, 8'h00);
  endtask

  // R4 R11 R2: identifier read, hold, ignored writes
  task automatic t_ident();
    wr(1'b1, 1'b0, 8'h90);
    wr(1'b0, 1'b1, 8'h00);
    rd("R4", 8'hEC);
    rd("R4", DEV);
    rd("R4", 8'hEC);
    repeat (3) @(negedge clk);
    chk("R11", "held offer", rd_data, DEV);
    wr(1'b1, 1'b1, 8'h70);
    chk("R2", "both qualifiers ignored", rd_data, DEV);
    wr(1'b0, 1'b0, 8'h70);
    chk("R2", "no qualifier ignored", rd_data, DEV);
    rd("R11", DEV);
    wr(1'b1, 1'b0, 8'h90);
    wr(1'b0, 1'b1, 8'h01);
    chk("R4", "bad id address", {7'b0, rd_valid}, 8'h00);
  endtask

  // R5: status byte with both write-protect levels
  task automatic t_status();
    wr(1'b1, 1'b0, 8'h70);
    rd("R5", 8'hC0);
    wp_n = 1'b0;
    @(negedge clk);
    rd("R5", 8'h40);
    wp_n = 1'b1;
  endtask

  // R6 R7 R9 R8: lower-half read with exact load time
  task automatic t_read_lo();
    page_addr(8'h00, 8'h05, 8'h34, 8'h12);
    chk("R6", "busy after last address", {7'b0, rb_n}, 8'h00);
    chk("R6", "no data while loading", {7'b0, rd_valid}, 8'h00);
    repeat (RDC - 1) @(negedge clk);
    chk("R6", "still loading", {7'b0, rb_n}, 8'h00);
    @(negedge clk);
    chk("R6", "ready after load", {7'b0, rb_n}, 8'h01);
    rd("R8", pat(8'h34, 5));
    rd("R9", pat(8'h34, 6));
    rd("R9", pat(8'h34, 7));
  endtask

  // R8: upper-half pointer
  task automatic t_read_hi();
    page_addr(8'h01, 8'h10, 8'h00, 8'h00);
    wait_ready();
    rd("R8", pat(8'h00, 272));
    rd("R8", pat(8'h00, 273));
  endtask

  // R7 R9: spare area and wrap to next row
  task automatic t_spare_wrap();
    page_addr(8'h50, 8'h1F, 8'h34, 8'h00);
    wait_ready();
    rd("R7", pat(8'h34, 527));
    rd("R9", pat(8'h35, 0));
    rd("R9", pat(8'h35, 1));
  endtask

  // R10: commands and addresses ignored while busy
  task automatic t_busy_ignore();
    page_addr(8'h00, 8'h00, 8'h22, 8'h00);
    wr(1'b1, 1'b0, 8'h90);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b0, 1'b1, 8'h40);
    wait_ready();
    rd("R10", pat(8'h22, 0));
  endtask

  // R5: status accepted while busy
  task automatic t_status_busy();
    page_addr(8'h00, 8'h00, 8'h01, 8'h00);
    wr(1'b1, 1'b0, 8'h70);
    rd("R5", 8'h80);
    wait_ready();
    rd("R5", 8'hC0);
  endtask

  // R3: reset while busy restarts the interval
  task automatic t_reset_busy();
    page_addr(8'h00, 8'h00, 8'h01, 8'h00);
    repeat (5) @(negedge clk);
    wr(1'b1, 1'b0, 8'hFF);
    repeat (RST - 1) @(negedge clk);
    chk("R3", "busy restarted", {7'b0, rb_n}, 8'h00);
    @(negedge clk);
    chk("R3", "ready after restart", {7'b0, rb_n}, 8'h01);
    chk("R3", "no data after abort", {7'b0, rd_valid}, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_powerup();
    t_reset_ready();
    t_ident();
    t_status();
    t_read_lo();
    t_read_hi();
    t_spare_wrap();
    t_busy_ignore();
    t_status_busy();
    t_reset_busy();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R1-watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule